// File: doc/BRIEF.md
# SPI Slave Front End with Hold Pause

This block sits between the four serial pins of a mode-0 SPI slave and the command, address and data logic behind them. It adds a pause pin (`hold_n_i`, active low) that freezes the serial transfer part-way through a byte. While paused, the bit position, the receive shift register and the transmit shift register all keep their values. Chip select, serial clock, serial data in and the pause pin are synchronised into a faster system clock domain. The system clock must run at least four times the serial clock rate. Every decision is taken on the synchronised levels and their edges.

A pause starts or ends only while the serial clock is low. If the pause pin changes while the clock is high, the change takes effect at the next falling clock edge. During a pause, data out is floated, and clock and data in are ignored. Releasing chip select during a pause resets the serial logic. The slave then stays locked out until the pause pin has been raised and only after that chip select is lowered again.

A small byte shifter shows the pause at work. It samples data in on rising clock edges, MSB first. It drives a per-bit shift strobe and a byte-complete strobe with the received byte. It shifts out a parallel byte MSB first, changing data out after each falling edge.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset the output enable, shift strobe, byte-complete strobe and logic-reset pulse are all low.
- R2: Every accepted rising serial-clock edge samples data in (MSB first) and gives one `shift_en_o` pulse. Every 8th accepted rise gives one `byte_done_o` pulse, and `rx_byte_o` then holds the 8 sampled bits with the first bit in bit 7.
- R3: While selected and not paused, `miso_oe_o` is high and `miso_o` presents `tx_byte_i` MSB first. The first bit is valid before the first rise, the output advances after each accepted falling edge, and a fresh `tx_byte_i` is loaded after the 8th bit. While deselected, `miso_oe_o` is low.
- R4: A falling edge on the pause pin while selected and with the serial clock low starts the pause at once, within the synchroniser latency.
- R5: A falling edge on the pause pin while the serial clock is high starts the pause only at the next falling clock edge. Rising edges before that point are still accepted.
- R6: A rising edge on the pause pin with the clock low ends the pause at once. With the clock high, the pause ends at the next falling clock edge, and that falling edge shifts nothing.
- R7: While paused, `miso_oe_o` is low, no shift or byte strobe occurs, and the bit position and shift registers keep their values. A byte split across a pause is received and sent intact.
- R8: A falling edge on the pause pin while deselected has no effect. Selecting with the pause pin already low gives a normal, unpaused transfer.
- R9: Deselecting during a pause gives exactly one `logic_rst_o` pulse and clears the bit position.
- R10: After R9 the slave stays floated and ignores the clock, even if reselected, until the pause pin is high and chip select has been high. Only a later select restarts communication.
- R11: Deselecting at any time clears the bit position, so the next select starts a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low (asynchronous) |
| sclk_i | input | 1 | Serial clock, idle low (asynchronous) |
| mosi_i | input | 1 | Serial data in (asynchronous) |
| hold_n_i | input | 1 | Pause request, active low (asynchronous) |
| tx_byte_i | input | 8 | Byte to shift out |
| miso_o | output | 1 | Serial data out value |
| miso_oe_o | output | 1 | Drive enable for serial data out |
| shift_en_o | output | 1 | One-cycle strobe per accepted bit |
| byte_done_o | output | 1 | One-cycle strobe per completed byte |
| rx_byte_o | output | 8 | Last completed received byte |
| logic_rst_o | output | 1 | One-cycle reset of the serial logic on deselect while paused |

## Verification
A change on the pause pin and a serial-clock edge can arrive in the same system cycle. The bench provokes this by lowering the pause pin while the clock is high, so the deferred entry coincides with the next falling edge. It also raises the pause pin while the clock is high, so the deferred exit coincides with a falling edge. The bench judges each case by whether the bit sent on data out and the received byte come out intact. It also counts shift strobes, so a falling edge that was wrongly masked or wrongly applied shows up.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic [2:0] {
    HS_IDLE,
    HS_ACTIVE,
    HS_ENTER_WAIT,
    HS_HELD,
    HS_EXIT_WAIT,
    HS_LOCKED
  } hold_st_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[gi] <= RST_VAL;
          else        stg[gi] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[gi] <= RST_VAL;
          else        stg[gi] <= stg[gi-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_q,
  input  logic sclk_q,
  input  logic hold_q,
  output logic rise_en_o,
  output logic fall_en_o,
  output logic drive_o,
  output logic held_o,
  output logic locked_o,
  output logic logic_rst_o
);
  hold_st_e st_q, st_d;
  logic sclk_p, hold_p;
  logic sclk_rise, sclk_fall, hold_fall, hold_rise;
  logic moving;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HS_IDLE;
      sclk_p <= 1'b0;
      hold_p <= 1'b1;
    end else begin
      st_q   <= st_d;
      sclk_p <= sclk_q;
      hold_p <= hold_q;
    end
  end

  assign sclk_rise = sclk_q & ~sclk_p;
  assign sclk_fall = ~sclk_q & sclk_p;
  assign hold_fall = ~hold_q & hold_p;
  assign hold_rise = hold_q & ~hold_p;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_IDLE: begin
        if (!cs_q) st_d = HS_ACTIVE;
      end
      HS_ACTIVE: begin
        if (cs_q)           st_d = HS_IDLE;
        else if (hold_fall) st_d = sclk_q ? HS_ENTER_WAIT : HS_HELD;
      end
      HS_ENTER_WAIT: begin
        if (cs_q)           st_d = HS_IDLE;
        else if (hold_q)    st_d = HS_ACTIVE;
        else if (!sclk_q)   st_d = HS_HELD;
      end
      HS_HELD: begin
        if (cs_q)           st_d = HS_LOCKED;
        else if (hold_rise) st_d = sclk_q ? HS_EXIT_WAIT : HS_ACTIVE;
      end
      HS_EXIT_WAIT: begin
        if (cs_q)           st_d = HS_LOCKED;
        else if (!hold_q)   st_d = HS_HELD;
        else if (!sclk_q)   st_d = HS_ACTIVE;
      end
      HS_LOCKED: begin
        if (cs_q && hold_q) st_d = HS_IDLE;
      end
      default: st_d = HS_IDLE;
    endcase
  end

  assign moving      = ((st_q == HS_ACTIVE) || (st_q == HS_ENTER_WAIT)) && !cs_q;
  assign rise_en_o   = moving & sclk_rise;
  assign fall_en_o   = moving & sclk_fall;
  assign drive_o     = moving;
  assign held_o      = (st_q == HS_HELD) || (st_q == HS_EXIT_WAIT);
  assign locked_o    = (st_q == HS_LOCKED);
  assign logic_rst_o = held_o & cs_q;
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              rise_en_i,
  input  logic              fall_en_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              miso_o,
  output logic              byte_done_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] rx_q, rx_d, tx_q, tx_d, out_q, out_d;
  logic              last_bit;

  assign last_bit = rise_en_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    rx_d  = rx_q;
    tx_d  = tx_q;
    out_d = out_q;
    if (clear_i) begin
      cnt_d = '0;
      rx_d  = '0;
      tx_d  = tx_byte_i;
    end else begin
      if (rise_en_i) begin
        rx_d  = {rx_q[DATA_W-2:0], mosi_i};
        cnt_d = last_bit ? '0 : cnt_q + 1'b1;
      end
      if (last_bit) out_d = {rx_q[DATA_W-2:0], mosi_i};
      if (fall_en_i) begin
        if (cnt_q == '0) tx_d = tx_byte_i;
        else             tx_d = {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
      out_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rx_q  <= rx_d;
      tx_q  <= tx_d;
      out_q <= out_d;
    end
  end

  assign miso_o      = tx_q[DATA_W-1];
  assign byte_done_o = last_bit;
  assign rx_byte_o   = out_q;
  assign bit_cnt_o   = cnt_q;
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              hold_n_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              shift_en_o,
  output logic              byte_done_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              logic_rst_o
);
  logic [1:0] rst_pipe;
  logic       rst_sn;
  logic [3:0] pins_q;
  logic       cs_q, hold_q, sclk_q, mosi_q;
  logic       rise_en, fall_en, drive, held_w, locked_w;
  logic [CNT_W-1:0] bit_cnt_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  spi_in_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b1100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_sn),
    .d_i  ({cs_n_i, hold_n_i, sclk_i, mosi_i}),
    .q_o  (pins_q)
  );
  assign {cs_q, hold_q, sclk_q, mosi_q} = pins_q;

  spi_hold_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sn),
    .cs_q       (cs_q),
    .sclk_q     (sclk_q),
    .hold_q     (hold_q),
    .rise_en_o  (rise_en),
    .fall_en_o  (fall_en),
    .drive_o    (drive),
    .held_o     (held_w),
    .locked_o   (locked_w),
    .logic_rst_o(logic_rst_o)
  );

  spi_byte_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_sn),
    .clear_i    (cs_q | logic_rst_o),
    .rise_en_i  (rise_en),
    .fall_en_i  (fall_en),
    .mosi_i     (mosi_q),
    .tx_byte_i  (tx_byte_i),
    .miso_o     (miso_o),
    .byte_done_o(byte_done_o),
    .rx_byte_o  (rx_byte_o),
    .bit_cnt_o  (bit_cnt_w)
  );

  assign miso_oe_o  = drive;
  assign shift_en_o = rise_en;
endmodule

// File: rtl/spi_hold_chk.sv
module spi_hold_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_q,
  input logic             held_w,
  input logic             locked_w,
  input logic             miso_oe_o,
  input logic             shift_en_o,
  input logic             byte_done_o,
  input logic             logic_rst_o,
  input logic [CNT_W-1:0] bit_cnt_w
);
  AST_HELD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    held_w |-> !miso_oe_o);                                   // R7
  AST_HELD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    held_w |-> (!shift_en_o && !byte_done_o));                // R7
  AST_HELD_KEEP_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (held_w && !cs_q) |=> $stable(bit_cnt_w));                // R7
  AST_DONE_HAS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_o |-> shift_en_o);                              // R2
  AST_RST_CLEARS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    logic_rst_o |=> (bit_cnt_w == '0));                       // R9
  AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> (bit_cnt_w == '0));                              // R11
  AST_DESEL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !miso_oe_o);                                     // R3
  AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    locked_w |-> (!miso_oe_o && !shift_en_o && !logic_rst_o)); // R10
endmodule

bind spi_hold_ctrl spi_hold_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_q       (cs_q),
  .held_w     (held_w),
  .locked_w   (locked_w),
  .miso_oe_o  (miso_oe_o),
  .shift_en_o (shift_en_o),
  .byte_done_o(byte_done_o),
  .logic_rst_o(logic_rst_o),
  .bit_cnt_w  (bit_cnt_w)
);

// File: tb/sim_spi_hold_ctrl.sv
module sim_spi_hold_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, sclk, mosi, hold_n;
  logic [7:0] tx_byte;
  logic       miso, miso_oe, shift_en, byte_done, logic_rst;
  logic [7:0] rx_byte;

  int checks = 0;
  int fails  = 0;
  int se_cnt = 0;
  int bd_cnt = 0;
  int lr_cnt = 0;
  logic [7:0] miso_cap;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_hold_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .mosi_i(mosi),
    .hold_n_i(hold_n), .tx_byte_i(tx_byte), .miso_o(miso), .miso_oe_o(miso_oe),
    .shift_en_o(shift_en), .byte_done_o(byte_done), .rx_byte_o(rx_byte),
    .logic_rst_o(logic_rst)
  );

  always @(posedge clk) begin
    if (shift_en)  se_cnt <= se_cnt + 1;
    if (byte_done) bd_cnt <= bd_cnt + 1;
    if (logic_rst) lr_cnt <= lr_cnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit cell: set data, capture data out, rise, fall
  task automatic bit_cell(input logic b, input int idx);
    mosi = b;
    waitc(6);
    miso_cap[7-idx] = miso;
    sclk = 1'b1;
    waitc(6);
    sclk = 1'b0;
    waitc(6);
  endtask

  task automatic send_bits(input logic [7:0] d, input int from, input int upto);
    for (int i = from; i <= upto; i++) bit_cell(d[7-i], i);
  endtask

  task automatic select();
    cs_n = 1'b0;
    waitc(6);
  endtask

  task automatic deselect();
    cs_n = 1'b1;
    waitc(6);
  endtask

  task automatic garbage_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      mosi = ~mosi;
      sclk = 1'b1; waitc(5);
      sclk = 1'b0; waitc(5);
    end
  endtask

  task automatic t_reset();
    waitc(2);
    check("R1 oe", miso_oe, 0);
    check("R1 shift", shift_en, 0);
    check("R1 done", byte_done, 0);
    check("R1 lrst", logic_rst, 0);
  endtask

  task automatic t_plain_byte();
    int se0, bd0;
    tx_byte = 8'h3C;
    waitc(4);
    check("R3 idle float", miso_oe, 0);
    select();
    check("R3 oe selected", miso_oe, 1);
    se0 = se_cnt; bd0 = bd_cnt;
    send_bits(8'hA5, 0, 7);
    check("R2 rx byte", rx_byte, 8'hA5);
    check("R2 shift count", se_cnt - se0, 8);
    check("R2 done count", bd_cnt - bd0, 1);
    check("R3 tx byte", miso_cap, 8'h3C);
    tx_byte = 8'hC3;
    send_bits(8'h5A, 0, 7);
    check("R2 second rx", rx_byte, 8'h5A);
    check("R3 second tx", miso_cap, 8'h3C);
    deselect();
  endtask

  task automatic t_hold_low();
    int se0, bd0;
    tx_byte = 8'h96;
    waitc(4);
    select();
    se0 = se_cnt; bd0 = bd_cnt;
    send_bits(8'hC9, 0, 2);
    hold_n = 1'b0;
    waitc(6);
    check("R4 float at once", miso_oe, 0);
    garbage_clocks(3);
    check("R7 no shift held", se_cnt - se0, 3);
    hold_n = 1'b1;
    waitc(6);
    check("R6 release low", miso_oe, 1);
    send_bits(8'hC9, 3, 7);
    check("R7 split rx", rx_byte, 8'hC9);
    check("R7 split tx", miso_cap, 8'h96);
    check("R7 split done", bd_cnt - bd0, 1);
    deselect();
  endtask

  task automatic t_hold_high();
    int se0;
    tx_byte = 8'hE1;
    waitc(4);
    select();
    se0 = se_cnt;
    send_bits(8'h6B, 0, 1);
    mosi = 1'b1;                 // bit 2 of 0x6B
    waitc(6);
    miso_cap[5] = miso;
    sclk = 1'b1;
    waitc(6);
    hold_n = 1'b0;
    waitc(6);
    check("R5 deferred entry", miso_oe, 1);
    check("R5 rise accepted", se_cnt - se0, 3);
    sclk = 1'b0;
    waitc(6);
    check("R5 held after fall", miso_oe, 0);
    garbage_clocks(2);
    sclk = 1'b1;
    waitc(5);
    hold_n = 1'b1;
    waitc(6);
    check("R6 deferred exit", miso_oe, 0);
    sclk = 1'b0;
    waitc(6);
    check("R6 exit on fall", miso_oe, 1);
    check("R6 no extra shift", se_cnt - se0, 3);
    send_bits(8'h6B, 3, 7);
    check("R7 deferred split rx", rx_byte, 8'h6B);
    check("R6 deferred split tx", miso_cap, 8'hE1);
    deselect();
  endtask

  task automatic t_desel_in_hold();
    int lr0, se0, bd0;
    tx_byte = 8'h81;
    waitc(4);
    select();
    lr0 = lr_cnt;
    send_bits(8'hFF, 0, 3);
    hold_n = 1'b0;
    waitc(6);
    deselect();
    check("R9 one reset pulse", lr_cnt - lr0, 1);
    select();                    // pause pin still low
    check("R10 stays floated", miso_oe, 0);
    se0 = se_cnt;
    garbage_clocks(3);
    check("R10 clock ignored", se_cnt - se0, 0);
    hold_n = 1'b1;
    waitc(6);
    check("R10 wrong order", miso_oe, 0);
    deselect();
    select();
    check("R10 restarted", miso_oe, 1);
    bd0 = bd_cnt;
    send_bits(8'h24, 0, 7);
    check("R9 fresh byte rx", rx_byte, 8'h24);
    check("R9 fresh byte tx", miso_cap, 8'h81);
    check("R9 one done", bd_cnt - bd0, 1);
    check("R9 no further reset", lr_cnt - lr0, 1);
    deselect();
  endtask

  task automatic t_desel_mid_byte();
    tx_byte = 8'h0F;
    waitc(4);
    select();
    send_bits(8'h00, 0, 2);
    deselect();
    select();
    send_bits(8'hB7, 0, 7);
    check("R11 fresh after deselect", rx_byte, 8'hB7);
    check("R11 tx restart", miso_cap, 8'h0F);
    deselect();
  endtask

  task automatic t_hold_while_desel();
    int lr0;
    tx_byte = 8'h77;
    lr0 = lr_cnt;
    hold_n = 1'b0;
    waitc(6);
    check("R8 no reset pulse", lr_cnt - lr0, 0);
    select();
    check("R8 not paused", miso_oe, 1);
    send_bits(8'h3E, 0, 7);
    check("R8 rx with pin low", rx_byte, 8'h3E);
    check("R8 tx with pin low", miso_cap, 8'h77);
    deselect();
    hold_n = 1'b1;
    waitc(6);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; hold_n = 1'b1;
    tx_byte = 8'h00; miso_cap = 8'h00;
    waitc(5);
    rst_n = 1'b1;
    waitc(4);
    t_reset();
    t_plain_byte();
    t_hold_low();
    t_hold_high();
    t_desel_in_hold();
    t_desel_mid_byte();
    t_hold_while_desel();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule